// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a word-addressed countdown timer for a processor's register space. Software loads a prescale divisor and an initial count while the timer is idle, then writes a start command. While it runs, a prescale counter divides the clock and removes one from the count each time it expires. Software can read the live count at any time.

The timer stops when the count reaches zero or when software writes a stop command. Start and stop commands are honoured only in the matching run state. The prescale and count registers cannot be written while the timer runs, so a running interval cannot be changed by accident. A `running` output mirrors the status bit for logic nearby.

Top module: `cdown_timer`

## Requirements
- R1: After reset, `running` is 0 and reads of the control, status, prescale and count registers all return 0.
- R2: Register word addresses are fixed: 0 is control (write bit 0 = start, bit 1 = stop; reads return 0), 1 is status (bit 0 = running, other bits read 0), 2 is prescale, 3 is count. Every access is a full 32-bit word, and a prescale value written while idle reads back in full.
- R3: A start command while idle with a nonzero count sets running from the next cycle. A start command while the count is 0 is ignored and running stays 0.
- R4: A prescale write while running is ignored, and the register keeps its earlier value.
- R5: A count write while idle loads the count. A count write while running is ignored. A read of the count register returns the live value.
- R6: With effective divisor P (the prescale value, where 0 counts as 1) and a start from count N, the count read k cycles after the start edge is N - floor(k/P), for k < N*P.
- R7: On the edge where the count goes from 1 to 0, running clears. The count then stays at 0.
- R8: A stop command while running clears running on the next edge and freezes the count. If that edge is also a prescale expiry, the stop wins and the count does not decrement. A later start reloads the full prescale period before the next decrement.
- R9: A start command while running has no effect and does not restart the prescale phase. A stop command while idle has no effect.
- R10: The `running` output always equals status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Access select |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| running | output | 1 | High while the timer counts |

## Verification
The hardest case to reach from the ports is a stop command that lands on the same edge as a prescale expiry, because only that edge shows whether stop takes priority over the decrement. The bench counts edges from the start command exactly, using a divisor of 4. It then times the stop write so that its edge is the eighth edge after a restart, which is an expiry. A start issued in the middle of a run is handled the same way: the count is read at a point where a restarted prescale phase would give a different value from an untouched one.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Word offsets of the registers
  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_PRESC = 2;
  localparam int OFS_COUNT = 3;
  // Control and status bit positions
  localparam int BIT_START = 0;
  localparam int BIT_STOP  = 1;
  localparam int BIT_RUN   = 0;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [DATA_W-1:0] divisor,
  output logic              tick
);
  logic [DATA_W-1:0] pre_q, pre_d, eff;
  logic              pre_en;

  always_comb begin
    eff    = (divisor == '0) ? DATA_W'(1) : divisor;
    tick   = run && (pre_q == DATA_W'(1));
    pre_en = load || run;
    pre_d  = pre_q;
    if (load || tick) pre_d = eff;
    else if (run)     pre_d = pre_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  AST_PRE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_q != '0)) else $error("prescale counter at zero while running"); // R6
endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic              start_ok,
  output logic              run_q,
  output logic [DATA_W-1:0] count_q
);
  logic              run_d, run_en, cnt_en;
  logic [DATA_W-1:0] count_d;
  logic              stop_ok;

  always_comb begin
    start_ok = start_cmd && !run_q && (count_q != '0);
    stop_ok  = stop_cmd && run_q;
    run_d    = run_q;
    count_d  = count_q;
    if (!run_q) begin
      if (cnt_wr)   count_d = wdata;
      if (start_ok) run_d   = 1'b1;
    end else if (stop_ok) begin
      run_d = 1'b0;
    end else if (tick) begin
      count_d = count_q - DATA_W'(1);
      if (count_q == DATA_W'(1)) run_d = 1'b0;
    end
    run_en = (run_d != run_q);
    cnt_en = (count_d != count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(start_cmd)) else $error("run began without start"); // R3
  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (count_q != '0)) else $error("running with zero count"); // R7
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !stop_cmd) |=> (count_q == $past(count_q) - DATA_W'(1))) else $error("missed decrement"); // R6
  AST_RUN_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_wr && !tick) |=> $stable(count_q)) else $error("count written while running"); // R5
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stop_cmd) |=> (!run_q && $stable(count_q))) else $error("stop not honoured"); // R8
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              run,
  input  logic [DATA_W-1:0] count,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] presc_q,
  output logic [DATA_W-1:0] bus_rdata
);
  import cdt_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

  logic wr, presc_wr, presc_en;

  always_comb begin
    wr        = bus_cs && bus_we;
    start_cmd = wr && (bus_addr == A_CTRL) && bus_wdata[BIT_START];
    stop_cmd  = wr && (bus_addr == A_CTRL) && bus_wdata[BIT_STOP];
    presc_wr  = wr && (bus_addr == A_PRESC);
    cnt_wr    = wr && (bus_addr == A_COUNT);
    presc_en  = presc_wr && !run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (presc_en) presc_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata[BIT_RUN] = run;
      A_PRESC: bus_rdata = presc_q;
      A_COUNT: bus_rdata = count;
      default: bus_rdata = '0;
    endcase
  end

  AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && presc_wr) |=> $stable(presc_q)) else $error("prescale written while running"); // R4
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              running
);
  logic              start_cmd, stop_cmd, cnt_wr, start_ok, tick, run_q;
  logic [DATA_W-1:0] presc_q, count_q;

  cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .run(run_q), .count(count_q),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .cnt_wr(cnt_wr),
    .presc_q(presc_q), .bus_rdata(bus_rdata)
  );

  cdt_prescaler #(.DATA_W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .run(run_q),
    .divisor(presc_q), .tick(tick)
  );

  cdt_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .cnt_wr(cnt_wr), .wdata(bus_wdata), .tick(tick), .start_ok(start_ok),
    .run_q(run_q), .count_q(count_q)
  );

  assign running = run_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(bus_cs && bus_we)) |=> $stable(count_q)) else $error("count moved while idle"); // R5
endmodule

// File: tb/test_cdown_timer.sv
module test_cdown_timer;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk, rst_n, bus_cs, bus_we, running;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cdown_timer #(.DATA_W(DW), .ADDR_W(AW)) i_cdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .running(running)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] presc;
    logic [31:0] init;
    logic [31:0] wait_n;
    logic [31:0] exp_cnt;
    logic [31:0] exp_run;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'd3, 32'd5,   32'd7,  32'd3,  32'd1},
    '{32'd0, 32'd4,   32'd2,  32'd2,  32'd1},
    '{32'd1, 32'd4,   32'd4,  32'd0,  32'd0},
    '{32'd2, 32'd3,   32'd10, 32'd0,  32'd0},
    '{32'd5, 32'd100, 32'd4,  32'd100,32'd1},
    '{32'd5, 32'd100, 32'd5,  32'd99, 32'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bus_cs = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, d); check("R1 reg", d, 32'd0); end
    check("R1 running", {31'd0, running}, 32'd0);

    // Vector table: R6, R7
    foreach (VEC[i]) begin
      wr(2, VEC[i].presc);
      wr(3, VEC[i].init);
      wr(0, 32'h1);
      idle(VEC[i].wait_n);
      rd(3, d); check("R6 count", d, VEC[i].exp_cnt);
      rd(1, d); check("R7 status", d, VEC[i].exp_run);
      check("R10 running", {31'd0, running}, VEC[i].exp_run);
      wr(0, 32'h2);
    end
    // R7 holds at zero after expiry
    wr(2, 32'd1); wr(3, 32'd2); wr(0, 32'h1);
    idle(9);
    rd(3, d); check("R7 hold zero", d, 32'd0);
    rd(1, d); check("R7 stopped", d, 32'd0);

    // R2 map
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check("R2 presc full", d, 32'hFFFF_FFFF);
    rd(0, d); check("R2 ctrl reads 0", d, 32'd0);

    // R4, R5, R9 while running (P=4, N=10)
    wr(2, 32'd4); wr(3, 32'd10);
    wr(0, 32'h1);              // start edge, k=0
    rd(1, d); check("R3 started", d, 32'd1);
    wr(2, 32'd1);              // k=1
    wr(3, 32'd77);             // k=2
    wr(0, 32'h1);              // k=3, start while running
    idle(2);                   // k=5
    rd(3, d); check("R9 start ignored / R5 live count", d, 32'd9);
    rd(2, d); check("R4 presc locked", d, 32'd4);
    wr(0, 32'h2);              // stop at k=6
    idle(10);
    rd(3, d); check("R8 frozen", d, 32'd9);
    rd(1, d); check("R8 stopped", d, 32'd0);

    // R8 restart reloads full period, then stop on an expiry edge
    wr(0, 32'h1);              // k=0
    idle(3);
    rd(3, d); check("R8 reload", d, 32'd9);
    idle(1);                   // k=4
    rd(3, d); check("R8 decrement", d, 32'd8);
    idle(3);                   // k=7
    wr(0, 32'h2);              // stop on edge 8 (expiry)
    idle(2);
    rd(3, d); check("R8 stop wins", d, 32'd8);

    // R9 stop while idle; R5 write while idle
    wr(0, 32'h2);
    rd(3, d); check("R9 idle stop", d, 32'd8);
    check("R9 running", {31'd0, running}, 32'd0);
    wr(3, 32'd2);
    rd(3, d); check("R5 idle write", d, 32'd2);

    // R3 start with zero count ignored
    wr(3, 32'd0); wr(0, 32'h1);
    idle(2);
    rd(1, d); check("R3 zero start", d, 32'd0);
    check("R10 running", {31'd0, running}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule